// File: doc/BRIEF.md
# Dual-Source Card Clock Divider

This block turns a requested card clock rate into an integer divider setting and a periodic clock-enable pulse for a storage-card interface. Two source tick streams are available: a fast general PLL tick and a 24 MHz crystal tick. Both are enables inside one clock domain. A request carries a rate code in hertz. The block divides the selected source rate by the requested rate. When the PLL ratio is too large for the 7-bit divider field, the block switches to the crystal source on its own. This lets the slow clocks of the card identification phase (a few hundred kHz) come out of the same logic as the fast data-transfer clocks.

The chosen configuration appears as a 16-bit register image that other logic can decode. Alongside it the block reports the rate it actually reached, which can differ from the request because the division truncates. A request that cannot be met raises a one-cycle error and leaves the configuration as it was. The divided output `card_en` counts ticks of the active source. A new setting is applied only once the period in progress has finished, so the card never sees a shortened cycle.

Top module: `cdiv_card_clk`

## Requirements
- R1: After reset the register image is 0x053B (crystal source, divider field 59), the reported rate is XTAL_HZ/60 (400000 with default parameters), and req_err is low.
- R2: When PLL_HZ / req_rate (integer division) lies in 1..127, the image takes source code 1 in bits 10:8 and ratio-1 in bits 6:0, with all other bits zero, on the clock edge that samples req_valid.
- R3: When the PLL ratio is above 127, the ratio is recomputed as XTAL_HZ / req_rate and source code 5 is written to bits 10:8, with that ratio minus one in bits 6:0. A crystal ratio of exactly 128 is accepted (field 127).
- R4: A request with req_rate equal to zero pulses req_err high for one cycle and leaves the image and the reported rate unchanged.
- R5: A request whose PLL ratio is zero, or whose crystal ratio after fallback is above 128, pulses req_err and leaves the image and the reported rate unchanged.
- R6: The reported rate equals the selected source rate divided by (divider field + 1), using integer division. It is updated together with the image.
- R7: card_en pulses for one cycle once every (field+1) ticks of the active source. A field of zero with a tick on every cycle keeps card_en high continuously.
- R8: A newly written divider or source takes effect only at the end of the current output period. The first pulse after a change still falls on the old period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_tick | input | 1 | One-cycle enable per general PLL source tick |
| xtal_tick | input | 1 | One-cycle enable per crystal source tick |
| req_valid | input | 1 | Request strobe, sampled on the rising edge |
| req_rate | input | 32 | Requested card clock rate in Hz |
| cfg_image | output | 16 | Source code in bits 10:8, divider field in bits 6:0 |
| rate_out | output | 32 | Achieved rate in Hz for the current image |
| req_err | output | 1 | One-cycle pulse when a request is rejected |
| card_en | output | 1 | Divided clock-enable pulse |

## Verification
The assertions assume the following about the inputs. `req_valid` is a single-cycle strobe, so every `req_err` can be traced to the request one cycle earlier. The tick inputs are plain enables that need no spacing. The active period counter is expected never to pass the field it loaded, and the active setting is expected to change only on a pulse. The stimulus drives every input at the falling edge and raises `req_valid` for one cycle per request. It holds `pll_tick` high and pulses `xtal_tick` once every four cycles, so each period length can be predicted in whole cycles. Requests are spaced so that each result is compared before the next one arrives, except in the boundary test, where a request is placed deliberately in the middle of a running period.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int unsigned DIV_W   = 7;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned RATE_W  = 32;
  localparam int unsigned IMG_W   = 16;
  localparam int unsigned SEL_LSB = 8;

  localparam logic [SEL_W-1:0] SRC_PLL  = 3'd1;
  localparam logic [SEL_W-1:0] SRC_XTAL = 3'd5;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } clk_cfg_t;

  typedef struct packed {
    logic              ok;
    clk_cfg_t          cfg;
    logic [RATE_W-1:0] rate;
  } calc_res_t;
endpackage

// File: rtl/cdiv_ratio_calc.sv
module cdiv_ratio_calc
  import cdiv_pkg::*;
#(
  parameter int unsigned PLL_HZ  = 600000000,
  parameter int unsigned XTAL_HZ = 24000000
) (
  input  logic [RATE_W-1:0] req_rate,
  output calc_res_t         result
);
  localparam logic [RATE_W-1:0] PLL_C    = RATE_W'(PLL_HZ);
  localparam logic [RATE_W-1:0] XTAL_C   = RATE_W'(XTAL_HZ);
  localparam logic [RATE_W-1:0] PLL_MAX  = RATE_W'((1 << DIV_W) - 1);
  localparam logic [RATE_W-1:0] XTAL_MAX = RATE_W'(1 << DIV_W);
  localparam logic [RATE_W-1:0] ONE      = RATE_W'(1);

  logic              zero_req;
  logic              use_xtal;
  logic              bad;
  logic [RATE_W-1:0] den;
  logic [RATE_W-1:0] pll_q;
  logic [RATE_W-1:0] xtal_q;
  logic [RATE_W-1:0] use_q;
  logic [RATE_W-1:0] safe_q;
  logic [RATE_W-1:0] src_c;

  always_comb begin
    zero_req = (req_rate == '0);
    den      = zero_req ? ONE : req_rate;
    pll_q    = PLL_C / den;
    xtal_q   = XTAL_C / den;
    // fall back to the crystal when the PLL ratio overflows the field
    use_xtal = (pll_q > PLL_MAX);
    use_q    = use_xtal ? xtal_q : pll_q;
    src_c    = use_xtal ? XTAL_C : PLL_C;
    bad      = zero_req || (use_q == '0) || (use_xtal && (xtal_q > XTAL_MAX));
    safe_q   = bad ? ONE : use_q;

    result.ok      = !bad;
    result.cfg.sel = use_xtal ? SRC_XTAL : SRC_PLL;
    result.cfg.div = DIV_W'(safe_q - ONE);
    result.rate    = src_c / safe_q;
  end
endmodule

// File: rtl/cdiv_cfg_reg.sv
module cdiv_cfg_reg
  import cdiv_pkg::*;
#(
  parameter int unsigned XTAL_HZ   = 24000000,
  parameter int unsigned RESET_DIV = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  calc_res_t         result,
  output clk_cfg_t          cfg_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              err_q
);
  localparam logic [DIV_W-1:0]  RST_DIV  = DIV_W'(RESET_DIV);
  localparam logic [RATE_W-1:0] RST_RATE = RATE_W'(XTAL_HZ / (RESET_DIV + 1));

  clk_cfg_t          cfg_d;
  logic [RATE_W-1:0] rate_d;
  logic              err_d;
  logic              load_en;

  always_comb begin
    load_en = req_valid && result.ok;
    cfg_d   = load_en ? result.cfg : cfg_q;
    rate_d  = load_en ? result.rate : rate_q;
    err_d   = req_valid && !result.ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.sel <= SRC_XTAL;
      cfg_q.div <= RST_DIV;
      rate_q    <= RST_RATE;
      err_q     <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      rate_q <= rate_d;
      err_q  <= err_d;
    end
  end

  AST_ERR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($stable(cfg_q) && $stable(rate_q)));  // R5
  AST_ERR_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(req_valid));  // R4
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.sel == SRC_PLL) || (cfg_q.sel == SRC_XTAL));  // R3
endmodule

// File: rtl/cdiv_pulse_gen.sv
module cdiv_pulse_gen
  import cdiv_pkg::*;
#(
  parameter int unsigned RESET_DIV = 59
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pll_tick,
  input  logic     xtal_tick,
  input  clk_cfg_t new_cfg,
  output logic     card_en
);
  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(RESET_DIV);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_div_q, act_div_d;
  logic [SEL_W-1:0] act_sel_q, act_sel_d;
  logic             en_d;
  logic             tick;
  logic             wrap;

  always_comb begin
    tick      = (act_sel_q == SRC_PLL) ? pll_tick : xtal_tick;
    wrap      = tick && (cnt_q == act_div_q);
    cnt_d     = wrap ? '0 : (tick ? cnt_q + 1'b1 : cnt_q);
    // pending setting is taken over only at a period boundary
    act_div_d = wrap ? new_cfg.div : act_div_q;
    act_sel_d = wrap ? new_cfg.sel : act_sel_q;
    en_d      = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      act_div_q <= RST_DIV;
      act_sel_q <= SRC_XTAL;
      card_en   <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      act_div_q <= act_div_d;
      act_sel_q <= act_sel_d;
      card_en   <= en_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_div_q);  // R7
  AST_SWITCH_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_div_q) || !$stable(act_sel_q)) |-> card_en);  // R8
endmodule

// File: rtl/cdiv_card_clk.sv
module cdiv_card_clk
  import cdiv_pkg::*;
#(
  parameter int unsigned PLL_HZ    = 600000000,
  parameter int unsigned XTAL_HZ   = 24000000,
  parameter int unsigned RESET_DIV = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_tick,
  input  logic              xtal_tick,
  input  logic              req_valid,
  input  logic [RATE_W-1:0] req_rate,
  output logic [IMG_W-1:0]  cfg_image,
  output logic [RATE_W-1:0] rate_out,
  output logic              req_err,
  output logic              card_en
);
  calc_res_t calc_res;
  clk_cfg_t  cfg_q;

  cdiv_ratio_calc #(
    .PLL_HZ  (PLL_HZ),
    .XTAL_HZ (XTAL_HZ)
  ) u_calc (
    .req_rate (req_rate),
    .result   (calc_res)
  );

  cdiv_cfg_reg #(
    .XTAL_HZ   (XTAL_HZ),
    .RESET_DIV (RESET_DIV)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .result    (calc_res),
    .cfg_q     (cfg_q),
    .rate_q    (rate_out),
    .err_q     (req_err)
  );

  cdiv_pulse_gen #(
    .RESET_DIV (RESET_DIV)
  ) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_tick  (pll_tick),
    .xtal_tick (xtal_tick),
    .new_cfg   (cfg_q),
    .card_en   (card_en)
  );

  always_comb begin
    cfg_image = '0;
    cfg_image[SEL_LSB +: SEL_W] = cfg_q.sel;
    cfg_image[DIV_W-1:0]        = cfg_q.div;
  end

  AST_IMG_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_image[7] == 1'b0) && (cfg_image[15:11] == '0));  // R2
endmodule

// File: tb/cdiv_card_clk_test.sv
module cdiv_card_clk_test;
  logic        clk;
  logic        rst_n;
  logic        pll_tick;
  logic        xtal_tick;
  logic        req_valid;
  logic [31:0] req_rate;
  logic [15:0] cfg_image;
  logic [31:0] rate_out;
  logic        req_err;
  logic        card_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] img;
    logic [31:0] rate;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  cdiv_card_clk uut (
    .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
    .req_valid(req_valid), .req_rate(req_rate), .cfg_image(cfg_image),
    .rate_out(rate_out), .req_err(req_err), .card_en(card_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // crystal tick: one cycle in four, driven at the falling edge
  initial begin
    xtal_tick = 1'b0;
    forever begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        xtal_tick = (i == 3);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare outputs one edge after each request
  initial begin
    forever begin
      @(posedge clk);
      if (req_valid === 1'b1) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          check(1'b0, "scoreboard empty", 0, 1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(cfg_image === e.img, {e.tag, " image"}, cfg_image, e.img);
          check(rate_out === e.rate, {e.tag, " rate"}, rate_out, e.rate);
          check(req_err === e.err, {e.tag, " err"}, req_err, e.err);
        end
      end
    end
  end

  task automatic push(input logic [15:0] img, input logic [31:0] rate, input logic err, input string tag);
    exp_t e;
    e.img = img; e.rate = rate; e.err = err; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic send(input logic [31:0] r, input logic [15:0] img,
                      input logic [31:0] rate, input logic err, input string tag);
    push(img, rate, err, tag);
    req_valid = 1'b1;
    req_rate  = r;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic next_gap(output int gap);
    gap = 0;
    while (card_en !== 1'b1) @(negedge clk);
    do begin
      @(negedge clk);
      gap++;
    end while (card_en !== 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int g;
    int n;
    rst_n = 1'b0; pll_tick = 1'b1; req_valid = 1'b0; req_rate = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfg_image === 16'h053B, "R1 reset image", cfg_image, 16'h053B);
    check(rate_out === 32'd400000, "R1 reset rate", rate_out, 400000);
    check(req_err === 1'b0, "R1 reset err", req_err, 0);
    rst_n = 1'b1;

    // R7 crystal period: 4 cycles per tick * 60
    next_gap(g); next_gap(g);
    check(g == 240, "R7 crystal gap", g, 240);

    // R2 R6 PLL path: 600M/25M = 24 -> field 23
    send(32'd25000000, 16'h0117, 32'd25000000, 1'b0, "R2 25MHz");
    next_gap(g); next_gap(g);
    check(g == 24, "R7 pll gap", g, 24);

    // R8 change mid period: next pulse stays on old boundary
    next_gap(g);
    n = 0;
    do begin
      if (n == 5) begin
        push(16'h0100, 32'd600000000, 1'b0, "R2 600MHz");
        req_valid = 1'b1;
        req_rate  = 32'd600000000;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end while (card_en !== 1'b1);
    req_valid = 1'b0;
    check(n == 24, "R8 old boundary kept", n, 24);
    next_gap(g);
    check(g == 1, "R7 field zero continuous", g, 1);
    check(card_en === 1'b1, "R7 field zero high", card_en, 1);

    // R3 fallback to crystal
    send(32'd400000, 16'h053B, 32'd400000, 1'b0, "R3 400kHz");
    send(32'd4687500, 16'h0504, 32'd4800000, 1'b0, "R3 pll ratio 128");
    // R2 largest PLL ratio 127, R6 truncated rate
    send(32'd4724409, 16'h017E, 32'd4724409, 1'b0, "R6 pll ratio 127");

    // R4 zero request, fields unchanged
    send(32'd0, 16'h017E, 32'd4724409, 1'b1, "R4 zero rate");
    check(req_err === 1'b0, "R4 err single cycle", req_err, 0);
    // R5 crystal ratio 133 rejected
    send(32'd180000, 16'h017E, 32'd4724409, 1'b1, "R5 xtal overflow");
    // R3 crystal ratio exactly 128 accepted
    send(32'd187500, 16'h057F, 32'd187500, 1'b0, "R3 xtal ratio 128");
    // R5 pll ratio zero rejected
    send(32'd700000000, 16'h057F, 32'd187500, 1'b1, "R5 pll ratio zero");

    // R7 crystal field 127: 4 * 128 cycles
    next_gap(g); next_gap(g);
    check(g == 512, "R7 crystal field 127 gap", g, 512);
    check(sb_q.size() == 0, "R6 scoreboard drained", sb_q.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule